// File: doc/BRIEF.md
# Three-Phase Bridge Command Matrix

This block sits between a motor controller's six PWM command lines and the gate drivers of a three-phase MOSFET bridge. Each phase (bit 0 = U, bit 1 = V, bit 2 = W) has one command for its upper switch and one for its lower switch. Both commands are active-low. A global enable input either lets the commands through or forces the whole bridge off. The block first brings every input into the clock domain through a multi-stage synchronizer. It then decodes each phase into a single leg request, so that a request for both switches, or for neither, means "leg off". A per-phase guard register then turns a gate on only after its leg has been fully off for a programmable number of clocks.

The outputs are registered gate enables, active-high. A reversal from upper to lower switch, or from lower to upper, never passes straight across. The leg first goes fully off, stays off for the dead time, and only then switches on the other side. Reset clears every output and loads the synchronizers with their inactive values: commands high, enable low. This matches a floating command line reading as inactive and a floating enable reading as off.

Top module: `bridge_cmd_matrix`

## Requirements
- R1: The three phases are independent and identical. Bit p of `cmd_hi_n`, `cmd_lo_n`, `gate_hi` and `gate_lo` all belong to phase p. A command bit of 0 requests the switch and a gate bit of 1 turns it on.
- R2: With `bridge_en` = 1, `cmd_hi_n[p]` = 0 and `cmd_lo_n[p]` = 1 held long enough, `gate_hi[p]` = 1 and `gate_lo[p]` = 0.
- R3: With `bridge_en` = 1, `cmd_lo_n[p]` = 0 and `cmd_hi_n[p]` = 1 held long enough, `gate_lo[p]` = 1 and `gate_hi[p]` = 0.
- R4: With `bridge_en` = 1 and the two commands of a phase equal (both 0 or both 1), both gates of that phase are 0.
- R5: With `bridge_en` = 0, all six gates are 0 whatever the commands are.
- R6: A synchronous active-low reset clears all gates. While reset is held, the gates stay 0 even if the inputs request switches.
- R7: When the dead time has already elapsed, a new request turns its gate on at the (SYNC_STAGES+1)-th rising edge after the input changes. With the default two stages this is the third edge, and the gate is not on earlier.
- R8: After both gates of a phase are off, neither gate of that phase rises until the leg has been off for DEAD_CYCLES consecutive clocks. On a direct reversal the off gap is exactly DEAD_CYCLES clocks.
- R9: The upper and lower gates of one phase are never 1 in the same cycle.
- R10: A gate that is on turns off at the same latency as R7 once its request is withdrawn.
- R11: If the enable drop reaches the guard on the same edge where the dead time completes, the enable drop wins and no gate rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_hi_n | input | PHASES | Upper-switch commands, active low, one bit per phase |
| cmd_lo_n | input | PHASES | Lower-switch commands, active low, one bit per phase |
| bridge_en | input | 1 | Global enable; 0 forces every gate off |
| gate_hi | output | PHASES | Upper gate enables, registered, active high |
| gate_lo | output | PHASES | Lower gate enables, registered, active high |

## Verification
Two events can land on the same edge of a phase guard: the dead-time counter reaching its threshold on a reversal, and a synchronized enable drop. The bench provokes this by reversing phase U and then dropping the enable exactly DEAD_CYCLES clocks later, so both reach the guard together. It then checks that the new gate never rises. A companion case drops the enable one clock later and expects the gate to pulse high for exactly one cycle, which shows that the timing of the first case really was on the boundary.

// File: rtl/gdm_pkg.sv
// Shared types for the bridge command matrix.
package gdm_pkg;

    // Decoded request for one bridge leg.
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_req_t;

endpackage

// File: rtl/gdm_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes each bit is a level that is held far longer than STAGES clocks,
// so no bus coherency is required. Reset loads RST_VAL into every stage.
module gdm_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/gdm_decode.sv
// Truth-table decode of one leg. Commands are active low. Equal commands
// (both asserted or both idle) and a low enable both give LEG_OFF.
// Purely combinational; the inputs are expected to be synchronized.
module gdm_decode
    import gdm_pkg::*;
(
    input  logic     hi_n,
    input  logic     lo_n,
    input  logic     en,
    output leg_req_t req
);

    // Map the command pair and the enable to a single leg request.
    always_comb begin
        req = LEG_OFF;
        if (en) begin
            unique case ({hi_n, lo_n})
                2'b01:   req = LEG_HIGH;
                2'b10:   req = LEG_LOW;
                default: req = LEG_OFF;
            endcase
        end
    end

endmodule

// File: rtl/gdm_leg_guard.sv
// Gate register and dead-time counter for one bridge leg. A gate may stay
// on while its request holds. It may switch on only when the leg has been
// fully off for DEAD_CYCLES clocks. Any change of request turns the leg off
// first. Assumes DEAD_CYCLES >= 1.
module gdm_leg_guard
    import gdm_pkg::*;
#(
    parameter int DEAD_CYCLES = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_req_t req,
    output logic     gate_hi,
    output logic     gate_lo
);

    localparam int             CW       = $clog2(DEAD_CYCLES + 1);
    localparam logic [CW-1:0]  READY_AT = CW'(DEAD_CYCLES - 1);

    logic [CW-1:0] idle_cnt;
    logic          leg_idle;
    logic          idle_ok;

    assign leg_idle = !gate_hi && !gate_lo;
    assign idle_ok  = leg_idle && (idle_cnt >= READY_AT);

    // Count consecutive fully-off cycles, saturating at the ready point.
    always_ff @(posedge clk) begin
        if (!rst_n)                   idle_cnt <= '0;
        else if (!leg_idle)           idle_cnt <= '0;
        else if (idle_cnt != READY_AT) idle_cnt <= idle_cnt + 1'b1;
    end

    // Hold an active gate while requested; start one only after the dead time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else begin
            gate_hi <= (req == LEG_HIGH) && (gate_hi || idle_ok);
            gate_lo <= (req == LEG_LOW)  && (gate_lo || idle_ok);
        end
    end

endmodule

// File: rtl/bridge_cmd_matrix.sv
// Three-phase bridge command matrix. It synchronizes the active-low switch
// commands and the global enable, decodes each phase into a leg request
// and applies a per-phase dead-time guard before the registered gate
// enables. Assumes the commands are asynchronous levels held much longer
// than SYNC_STAGES + DEAD_CYCLES clocks.
module bridge_cmd_matrix #(
    parameter int PHASES      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHASES-1:0] cmd_hi_n,
    input  logic [PHASES-1:0] cmd_lo_n,
    input  logic              bridge_en,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo
);

    import gdm_pkg::*;

    logic [PHASES-1:0] hi_n_s;
    logic [PHASES-1:0] lo_n_s;
    logic              en_s;

    // Upper commands: idle (high) out of reset.
    gdm_sync #(.WIDTH(PHASES), .STAGES(SYNC_STAGES), .RST_VAL({PHASES{1'b1}})) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .d(cmd_hi_n), .q(hi_n_s)
    );

    // Lower commands: idle (high) out of reset.
    gdm_sync #(.WIDTH(PHASES), .STAGES(SYNC_STAGES), .RST_VAL({PHASES{1'b1}})) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .d(cmd_lo_n), .q(lo_n_s)
    );

    // Enable: off out of reset.
    gdm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(bridge_en), .q(en_s)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        leg_req_t req;

        gdm_decode u_dec (
            .hi_n(hi_n_s[p]), .lo_n(lo_n_s[p]), .en(en_s), .req(req)
        );

        gdm_leg_guard #(.DEAD_CYCLES(DEAD_CYCLES)) u_guard (
            .clk(clk), .rst_n(rst_n), .req(req),
            .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
        );
    end

endmodule

// File: rtl/gdm_bridge_checker.sv
// Property checker for bridge_cmd_matrix, bound to every instance. It keeps
// its own count of fully-off cycles per phase to judge the dead time.
module gdm_bridge_checker #(
    parameter int PHASES      = 3,
    parameter int DEAD_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHASES-1:0] hi_n_s,
    input logic [PHASES-1:0] lo_n_s,
    input logic              en_s,
    input logic [PHASES-1:0] gate_hi,
    input logic [PHASES-1:0] gate_lo
);

    localparam int GW = $clog2(DEAD_CYCLES + 1);

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == '0) && (gate_lo == '0));   // R6

    AST_MUTE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> (gate_hi == '0) && (gate_lo == '0));    // R5

    AST_NO_SHOOT_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);                       // R9

    for (genvar p = 0; p < PHASES; p++) begin : g_chk
        logic [GW-1:0] gap;

        // Independent count of consecutive cycles with both gates off.
        always_ff @(posedge clk) begin
            if (!rst_n)                         gap <= '0;
            else if (gate_hi[p] || gate_lo[p])  gap <= '0;
            else if (gap != GW'(DEAD_CYCLES))   gap <= gap + 1'b1;
        end

        AST_HI_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[p]) |-> $past(en_s && !hi_n_s[p] && lo_n_s[p]));  // R2

        AST_LO_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_lo[p]) |-> $past(en_s && !lo_n_s[p] && hi_n_s[p]));  // R3

        AST_EQUAL_CMD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_n_s[p] == lo_n_s[p]) |=> !gate_hi[p] && !gate_lo[p]);        // R4

        AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_hi[p]) || $rose(gate_lo[p])) |-> gap >= GW'(DEAD_CYCLES));  // R8
    end

endmodule

bind bridge_cmd_matrix gdm_bridge_checker #(
    .PHASES(PHASES), .DEAD_CYCLES(DEAD_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hi_n_s(hi_n_s), .lo_n_s(lo_n_s), .en_s(en_s),
    .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/bridge_cmd_matrix_test.sv
module bridge_cmd_matrix_test;

    localparam int PH   = 3;
    localparam int DEAD = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [PH-1:0] cmd_hi_n;
    logic [PH-1:0] cmd_lo_n;
    logic          bridge_en;
    logic [PH-1:0] gate_hi;
    logic [PH-1:0] gate_lo;

    int checks = 0;
    int fails  = 0;
    int shoot  = 0;

    always #2 clk = ~clk;

    bridge_cmd_matrix #(.PHASES(PH), .SYNC_STAGES(2), .DEAD_CYCLES(DEAD)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
        .bridge_en(bridge_en), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Steady-state gates {lo, hi} expected from the truth table.
    function automatic logic [2*PH-1:0] expect_gates(logic [PH-1:0] hn, logic [PH-1:0] ln, logic en);
        logic [PH-1:0] h, l;
        for (int p = 0; p < PH; p++) begin
            h[p] = en & ~hn[p] & ln[p];
            l[p] = en & ~ln[p] & hn[p];
        end
        return {l, h};
    endfunction

    // Shoot-through monitor for R9.
    always @(negedge clk)
        if (rst_n === 1'b1 && (gate_hi & gate_lo) != '0) shoot++;

    initial begin
        #(4 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int gap;
        int high_cnt;
        // R6: reset held while the inputs request switches.
        rst_n = 1'b0; cmd_hi_n = 3'b010; cmd_lo_n = 3'b101; bridge_en = 1'b1;
        tick(6);
        check({gate_lo, gate_hi} == '0, "R6 reset", {gate_lo, gate_hi}, 0);
        cmd_hi_n = '1; cmd_lo_n = '1;
        rst_n = 1'b1;
        tick(DEAD + 6);

        // R1 R2 R3 R4 R5: all 128 steady input patterns.
        for (int c = 0; c < 128; c++) begin
            logic [2*PH-1:0] e;
            {bridge_en, cmd_lo_n, cmd_hi_n} = 7'(c);
            tick(3 + DEAD + 4);
            e = expect_gates(cmd_hi_n, cmd_lo_n, bridge_en);
            check({gate_lo, gate_hi} == e, "R1 R2 R3 R4 R5 sweep", {gate_lo, gate_hi}, e);
        end

        // R7: on-latency with the dead time already satisfied.
        bridge_en = 1'b1; cmd_hi_n = '1; cmd_lo_n = '1;
        tick(DEAD + 6);
        cmd_hi_n = 3'b110;
        tick(2);
        check(gate_hi == 3'b000, "R7 not early", gate_hi, 0);
        tick(1);
        check(gate_hi == 3'b001, "R7 third edge", gate_hi, 1);

        // R10 and R8: reversal, off-latency then exact gap.
        tick(DEAD + 4);
        cmd_hi_n = 3'b111; cmd_lo_n = 3'b110;
        tick(2);
        check(gate_hi[0] == 1'b1, "R10 still on", gate_hi[0], 1);
        tick(1);
        check(gate_hi[0] == 1'b0, "R10 off third edge", gate_hi[0], 0);
        gap = 1;
        for (int k = 0; k < 50; k++) begin
            tick(1);
            if (gate_lo[0]) break;
            gap++;
        end
        check(gap == DEAD, "R8 dead gap", gap, DEAD);

        // R11: enable drop lands on the dead-time expiry edge.
        tick(DEAD + 4);
        cmd_hi_n = 3'b110; cmd_lo_n = 3'b111;
        tick(DEAD);
        bridge_en = 1'b0;
        high_cnt = 0;
        for (int k = 0; k < 12; k++) begin
            tick(1);
            if (gate_hi[0]) high_cnt++;
        end
        check(high_cnt == 0, "R11 coincident drop", high_cnt, 0);

        // R11 companion: drop one clock later gives a one-cycle pulse.
        bridge_en = 1'b1; cmd_hi_n = 3'b111; cmd_lo_n = 3'b110;
        tick(3 + DEAD + 6);
        cmd_hi_n = 3'b110; cmd_lo_n = 3'b111;
        tick(DEAD + 1);
        bridge_en = 1'b0;
        high_cnt = 0;
        for (int k = 0; k < 12; k++) begin
            tick(1);
            if (gate_hi[0]) high_cnt++;
        end
        check(high_cnt == 1, "R11 late drop pulse", high_cnt, 1);

        check(shoot == 0, "R9 shoot-through", shoot, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule